// File: doc/BRIEF.md
# Prioritized Access Permission Checker

This block turns the per-entry results of an I/O memory protection unit into one verdict for each transaction. An upstream stage has already compared the transaction's address range against every rule entry and resolved which entries belong to the requester's memory domains. This block receives those results as bit vectors, one bit per entry. It also receives the requester's role identifier, the access kind and a few configuration values. It reports whether the access is allowed and, if it is not, a 4-bit error code. It also reports the index of the entry that settled the outcome, and the set of associated non-priority entries that covered the whole transaction.

Entries below a programmable boundary are priority entries. They are ordered by index, and the first associated one that touches any byte of the transaction settles the outcome on its own. Entries at or above the boundary share the lowest priority. Among them, any one that covers the whole transaction and grants the access is enough to allow it. Each request is captured on a clock edge when `req_valid` is high, and the verdict appears on the registered outputs one cycle later.

Internally, each request is sorted into one of seven decision classes:
- DEC_RRID: unknown requester.
- DEC_BLOCKED: write or fetch globally disabled.
- DEC_PRIO_PART: a priority entry hits only some bytes.
- DEC_PRIO_FULL: a priority entry covers the whole transaction.
- DEC_NP_GRANT: a non-priority entry grants the access.
- DEC_NP_DENY: non-priority entries cover the access but none grants it.
- DEC_NONE: no qualifying entry.

The classes are tested in the order listed, and the first one that applies is taken. The registered outputs are updated from the chosen class.

Top module: `acc_perm_checker`

## Requirements
- R1: A requester identifier that is equal to or greater than `cfg_rrid_num` gives error code 0x06. This check comes before every other check, and in this case `rsp_entry` and `rsp_np_mask` are zero.
- R2: The access code is 0 for a read, 1 for a write and 2 for an instruction fetch; code 3 is handled as a read. For a known requester, a write while `cfg_no_w` is 1 gives 0x05, and so does a fetch while `cfg_no_x` is 1. This check comes before entry matching, and in this case `rsp_entry` and `rsp_np_mask` are zero.
- R3: Entry i is a priority entry when i < `cfg_prio_entry`. A lower index has higher priority. Entries not set in `assoc` are ignored. The deciding entry is the lowest-index associated priority entry whose `hit_any` bit is set, and its index appears on `rsp_entry`.
- R4: If the deciding priority entry has `hit_all` clear, the result is 0x04, whatever its permission bits are.
- R5: If the deciding priority entry has `hit_all` set, the access is legal when the entry grants it. Otherwise the result is 0x01 for a read, 0x02 for a write or 0x03 for a fetch.
- R6: If no priority entry decides, the access is legal when any associated non-priority entry with `hit_all` set grants it. `rsp_entry` is then the lowest-index granting entry.
- R7: If associated non-priority entries cover the whole access but none of them grants it, the result is 0x01, 0x02 or 0x03 by access kind, and `rsp_entry` is the lowest such entry. Whenever entry matching is reached, `rsp_np_mask` lists every associated non-priority entry with `hit_all` set.
- R8: If no entry qualifies, the result is 0x05 with `rsp_entry` zero. A non-priority entry that hits only some bytes does not qualify.
- R9: A fetch is checked against the x bit when `cfg_chk_x` is 1, and against the r bit when it is 0. A read is checked against r and a write against w.
- R10: After reset all outputs are zero. `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the other outputs change only then. `rsp_legal` is 1 exactly when `rsp_err` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Capture the request on this edge |
| req_rrid | input | RRID_W | Requester role identifier |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| hit_any | input | NUM_ENTRIES | Entry hits at least one byte |
| hit_all | input | NUM_ENTRIES | Entry covers every byte |
| perm_r | input | NUM_ENTRIES | Per-entry read permission |
| perm_w | input | NUM_ENTRIES | Per-entry write permission |
| perm_x | input | NUM_ENTRIES | Per-entry fetch permission |
| assoc | input | NUM_ENTRIES | Entry belongs to a domain of the requester |
| cfg_rrid_num | input | RRID_W+1 | Number of known requester identifiers |
| cfg_prio_entry | input | clog2(NUM_ENTRIES+1) | Priority boundary |
| cfg_no_w | input | 1 | Reject all writes |
| cfg_no_x | input | 1 | Reject all fetches |
| cfg_chk_x | input | 1 | Check fetches against x instead of r |
| rsp_valid | output | 1 | Verdict present this cycle |
| rsp_legal | output | 1 | Access allowed |
| rsp_err | output | 4 | Error code, 0x00 when legal |
| rsp_entry | output | clog2(NUM_ENTRIES) | Deciding entry index |
| rsp_np_mask | output | NUM_ENTRIES | Associated fully hit non-priority entries |

## Verification
The bench builds the block with its defaults: eight entries and a 4-bit requester identifier. It sets the boundary to 4 for most scenarios, so priority ordering and unordered non-priority matching can be exercised together in one vector. It also moves the boundary to 0, which makes every entry non-priority, and uses `cfg_rrid_num` of 8. That value puts the last legal identifier and the first rejected one within four bits.

// File: rtl/apc_pkg.sv
package apc_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [3:0] {
        ERR_NONE    = 4'h0,
        ERR_RD      = 4'h1,
        ERR_WR      = 4'h2,
        ERR_FX      = 4'h3,
        ERR_PARTIAL = 4'h4,
        ERR_NOHIT   = 4'h5,
        ERR_RRID    = 4'h6
    } err_e;

    typedef enum logic [2:0] {
        DEC_RRID,
        DEC_BLOCKED,
        DEC_PRIO_PART,
        DEC_PRIO_FULL,
        DEC_NP_GRANT,
        DEC_NP_DENY,
        DEC_NONE
    } dec_e;

    function automatic err_e perm_err(input acc_e a);
        unique case (a)
            ACC_WRITE: return ERR_WR;
            ACC_FETCH: return ERR_FX;
            default:   return ERR_RD;
        endcase
    endfunction

endpackage

// File: rtl/apc_grant.sv
module apc_grant
    import apc_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  acc_e                   acc,
    input  logic                   chk_x,
    input  logic [NUM_ENTRIES-1:0] pr,
    input  logic [NUM_ENTRIES-1:0] pw,
    input  logic [NUM_ENTRIES-1:0] px,
    output logic [NUM_ENTRIES-1:0] grant
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        always_comb begin
            unique case (acc)
                ACC_WRITE: grant[g] = pw[g];
                ACC_FETCH: grant[g] = chk_x ? px[g] : pr[g];
                default:   grant[g] = pr[g];
            endcase
        end
    end

endmodule

// File: rtl/apc_first_one.sv
module apc_first_one #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/apc_decide.sv
module apc_decide
    import apc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             rrid_ok,
    input  acc_e             acc,
    input  logic             no_w,
    input  logic             no_x,
    input  logic             prio_found,
    input  logic [IDX_W-1:0] prio_idx,
    input  logic             prio_full,
    input  logic             prio_grant,
    input  logic             npg_found,
    input  logic [IDX_W-1:0] npg_idx,
    input  logic             npf_found,
    input  logic [IDX_W-1:0] npf_idx,
    output dec_e             dec,
    output logic             legal,
    output err_e             err,
    output logic [IDX_W-1:0] entry
);

    logic blocked;
    assign blocked = (acc == ACC_WRITE && no_w) || (acc == ACC_FETCH && no_x);

    always_comb begin
        if (!rrid_ok)        dec = DEC_RRID;
        else if (blocked)    dec = DEC_BLOCKED;
        else if (prio_found) dec = prio_full ? DEC_PRIO_FULL : DEC_PRIO_PART;
        else if (npg_found)  dec = DEC_NP_GRANT;
        else if (npf_found)  dec = DEC_NP_DENY;
        else                 dec = DEC_NONE;
    end

    always_comb begin
        legal = 1'b0;
        err   = ERR_NONE;
        entry = '0;
        unique case (dec)
            DEC_RRID:      err = ERR_RRID;
            DEC_BLOCKED:   err = ERR_NOHIT;
            DEC_PRIO_PART: begin
                err   = ERR_PARTIAL;
                entry = prio_idx;
            end
            DEC_PRIO_FULL: begin
                legal = prio_grant;
                err   = prio_grant ? ERR_NONE : perm_err(acc);
                entry = prio_idx;
            end
            DEC_NP_GRANT: begin
                legal = 1'b1;
                entry = npg_idx;
            end
            DEC_NP_DENY: begin
                err   = perm_err(acc);
                entry = npf_idx;
            end
            default:       err = ERR_NOHIT;
        endcase
    end

endmodule

// File: rtl/acc_perm_checker.sv
module acc_perm_checker
    import apc_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int RRID_W      = 4,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int PRIO_W     = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [RRID_W-1:0]      req_rrid,
    input  logic [1:0]             req_acc,
    input  logic [NUM_ENTRIES-1:0] hit_any,
    input  logic [NUM_ENTRIES-1:0] hit_all,
    input  logic [NUM_ENTRIES-1:0] perm_r,
    input  logic [NUM_ENTRIES-1:0] perm_w,
    input  logic [NUM_ENTRIES-1:0] perm_x,
    input  logic [NUM_ENTRIES-1:0] assoc,
    input  logic [RRID_W:0]        cfg_rrid_num,
    input  logic [PRIO_W-1:0]      cfg_prio_entry,
    input  logic                   cfg_no_w,
    input  logic                   cfg_no_x,
    input  logic                   cfg_chk_x,
    output logic                   rsp_valid,
    output logic                   rsp_legal,
    output logic [3:0]             rsp_err,
    output logic [IDX_W-1:0]       rsp_entry,
    output logic [NUM_ENTRIES-1:0] rsp_np_mask
);

    acc_e                   acc;
    logic [NUM_ENTRIES-1:0] is_prio, grant, cand_prio, np_full, np_grant;
    logic                   rrid_ok, prio_found, npg_found, npf_found;
    logic [IDX_W-1:0]       prio_idx, npg_idx, npf_idx, entry_d;
    logic                   legal_d;
    err_e                   err_d;
    dec_e                   dec_d;
    logic [NUM_ENTRIES-1:0] mask_d;

    assign acc     = acc_e'(req_acc);
    assign rrid_ok = {1'b0, req_rrid} < cfg_rrid_num;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_prio
        assign is_prio[g] = PRIO_W'(g) < cfg_prio_entry;
    end

    apc_grant #(.NUM_ENTRIES(NUM_ENTRIES)) u_grant (
        .acc   (acc),
        .chk_x (cfg_chk_x),
        .pr    (perm_r),
        .pw    (perm_w),
        .px    (perm_x),
        .grant (grant)
    );

    assign cand_prio = assoc & hit_any & is_prio;
    assign np_full   = assoc & hit_all & ~is_prio;
    assign np_grant  = np_full & grant;

    apc_first_one #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_prio (
        .vec (cand_prio), .found (prio_found), .idx (prio_idx)
    );

    apc_first_one #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_npg (
        .vec (np_grant), .found (npg_found), .idx (npg_idx)
    );

    apc_first_one #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_npf (
        .vec (np_full), .found (npf_found), .idx (npf_idx)
    );

    apc_decide #(.IDX_W(IDX_W)) u_decide (
        .rrid_ok    (rrid_ok),
        .acc        (acc),
        .no_w       (cfg_no_w),
        .no_x       (cfg_no_x),
        .prio_found (prio_found),
        .prio_idx   (prio_idx),
        .prio_full  (hit_all[prio_idx]),
        .prio_grant (grant[prio_idx]),
        .npg_found  (npg_found),
        .npg_idx    (npg_idx),
        .npf_found  (npf_found),
        .npf_idx    (npf_idx),
        .dec        (dec_d),
        .legal      (legal_d),
        .err        (err_d),
        .entry      (entry_d)
    );

    assign mask_d = (dec_d == DEC_RRID || dec_d == DEC_BLOCKED) ? '0 : np_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_legal   <= 1'b0;
            rsp_err     <= 4'h0;
            rsp_entry   <= '0;
            rsp_np_mask <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_legal   <= legal_d;
                rsp_err     <= err_d;
                rsp_entry   <= entry_d;
                rsp_np_mask <= mask_d;
            end
        end
    end

endmodule

// File: rtl/apc_checker.sv
module apc_checker #(
    parameter int NUM_ENTRIES = 8,
    parameter int RRID_W      = 4,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int PRIO_W     = $clog2(NUM_ENTRIES + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [RRID_W-1:0]      req_rrid,
    input logic [1:0]             req_acc,
    input logic [NUM_ENTRIES-1:0] hit_any,
    input logic [NUM_ENTRIES-1:0] hit_all,
    input logic [NUM_ENTRIES-1:0] assoc,
    input logic [RRID_W:0]        cfg_rrid_num,
    input logic [PRIO_W-1:0]      cfg_prio_entry,
    input logic                   cfg_no_w,
    input logic                   cfg_no_x,
    input logic                   rsp_valid,
    input logic                   rsp_legal,
    input logic [3:0]             rsp_err,
    input logic [IDX_W-1:0]       rsp_entry,
    input logic [NUM_ENTRIES-1:0] rsp_np_mask
);

    logic known, blocked;
    assign known   = {1'b0, req_rrid} < cfg_rrid_num;
    assign blocked = (req_acc == 2'd1 && cfg_no_w) || (req_acc == 2'd2 && cfg_no_x);

    p_rrid_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !known |=> rsp_err == 4'h6 && !rsp_legal && rsp_np_mask == '0);

    p_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && known && blocked |=> rsp_err == 4'h5 && rsp_entry == '0);

    p_partial_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && known && !blocked && cfg_prio_entry != '0 &&
        assoc[0] && hit_any[0] && !hit_all[0] |=> rsp_err == 4'h4 && rsp_entry == '0);

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(rsp_err) && $stable(rsp_entry) && $stable(rsp_legal));

    p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_legal == (rsp_err == 4'h0) || (!rsp_legal && rsp_err == 4'h0 && !rsp_valid));

endmodule

bind acc_perm_checker apc_checker #(.NUM_ENTRIES(NUM_ENTRIES), .RRID_W(RRID_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_rrid       (req_rrid),
    .req_acc        (req_acc),
    .hit_any        (hit_any),
    .hit_all        (hit_all),
    .assoc          (assoc),
    .cfg_rrid_num   (cfg_rrid_num),
    .cfg_prio_entry (cfg_prio_entry),
    .cfg_no_w       (cfg_no_w),
    .cfg_no_x       (cfg_no_x),
    .rsp_valid      (rsp_valid),
    .rsp_legal      (rsp_legal),
    .rsp_err        (rsp_err),
    .rsp_entry      (rsp_entry),
    .rsp_np_mask    (rsp_np_mask)
);

// File: tb/tb_acc_perm_checker.sv
`timescale 1ns/1ps
module tb_acc_perm_checker;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_rrid = '0;
    logic [1:0] req_acc = '0;
    logic [N-1:0] hit_any = '0, hit_all = '0, perm_r = '0, perm_w = '0, perm_x = '0, assoc = '0;
    logic [4:0] cfg_rrid_num = 5'd8;
    logic [3:0] cfg_prio_entry = 4'd4;
    logic       cfg_no_w = 1'b0, cfg_no_x = 1'b0, cfg_chk_x = 1'b1;
    logic       rsp_valid, rsp_legal;
    logic [3:0] rsp_err;
    logic [2:0] rsp_entry;
    logic [N-1:0] rsp_np_mask;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acc_perm_checker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rrid(req_rrid),
        .req_acc(req_acc), .hit_any(hit_any), .hit_all(hit_all), .perm_r(perm_r),
        .perm_w(perm_w), .perm_x(perm_x), .assoc(assoc), .cfg_rrid_num(cfg_rrid_num),
        .cfg_prio_entry(cfg_prio_entry), .cfg_no_w(cfg_no_w), .cfg_no_x(cfg_no_x),
        .cfg_chk_x(cfg_chk_x), .rsp_valid(rsp_valid), .rsp_legal(rsp_legal),
        .rsp_err(rsp_err), .rsp_entry(rsp_entry), .rsp_np_mask(rsp_np_mask)
    );

    task automatic expect_rsp(input string tag, input logic v, input logic lg,
                              input logic [3:0] er, input logic [2:0] en, input logic [N-1:0] mk);
        n_checks++;
        if (rsp_valid !== v || rsp_legal !== lg || rsp_err !== er || rsp_entry !== en || rsp_np_mask !== mk) begin
            n_fail++;
            $display("FAIL %s: got v=%b legal=%b err=%h entry=%0d mask=%b, want v=%b legal=%b err=%h entry=%0d mask=%b",
                     tag, rsp_valid, rsp_legal, rsp_err, rsp_entry, rsp_np_mask, v, lg, er, en, mk);
        end
    endtask

    task automatic fire();
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_entries();
        hit_any = '0; hit_all = '0; perm_r = '0; perm_w = '0; perm_x = '0; assoc = '0;
        cfg_no_w = 1'b0; cfg_no_x = 1'b0; cfg_chk_x = 1'b1; cfg_prio_entry = 4'd4;
        req_rrid = 4'd1; req_acc = 2'd0;
    endtask

    task automatic t_rrid();
        clear_entries();
        hit_any = 8'h01; hit_all = 8'h01; perm_r = 8'hFF; perm_w = 8'hFF; perm_x = 8'hFF; assoc = 8'hFF;
        req_rrid = 4'd8; fire();
        expect_rsp("R1 rrid at limit", 1, 0, 4'h6, 0, 8'h00);
        req_rrid = 4'd7; fire();
        expect_rsp("R1 rrid just below limit", 1, 1, 4'h0, 0, 8'h00);
        req_rrid = 4'd9; req_acc = 2'd1; cfg_no_w = 1'b1; fire();
        expect_rsp("R1 rrid before no_w", 1, 0, 4'h6, 0, 8'h00);
    endtask

    task automatic t_blocked();
        clear_entries();
        hit_any = 8'h24; hit_all = 8'h24; perm_r = 8'hFF; perm_w = 8'hFF; perm_x = 8'hFF; assoc = 8'hFF;
        cfg_no_w = 1'b1; req_acc = 2'd1; fire();
        expect_rsp("R2 no_w write", 1, 0, 4'h5, 0, 8'h00);
        req_acc = 2'd0; fire();
        expect_rsp("R2 no_w read passes", 1, 1, 4'h0, 2, 8'h20);
        cfg_no_w = 1'b0; cfg_no_x = 1'b1; req_acc = 2'd2; fire();
        expect_rsp("R2 no_x fetch", 1, 0, 4'h5, 0, 8'h00);
    endtask

    task automatic t_prio_order();
        clear_entries();
        hit_any = 8'h06; hit_all = 8'h06; perm_r = 8'h06; perm_w = 8'h04; assoc = 8'h06;
        req_acc = 2'd1; fire();
        expect_rsp("R3 lower index decides", 1, 0, 4'h2, 1, 8'h00);
        assoc = 8'h04; fire();
        expect_rsp("R3 unassociated entry ignored", 1, 1, 4'h0, 2, 8'h00);
    endtask

    task automatic t_partial();
        clear_entries();
        hit_any = 8'h28; hit_all = 8'h20; perm_r = 8'hFF; perm_w = 8'hFF; perm_x = 8'hFF; assoc = 8'hFF;
        fire();
        expect_rsp("R4 partial priority hit", 1, 0, 4'h4, 3, 8'h20);
    endtask

    task automatic t_prio_perm();
        clear_entries();
        hit_any = 8'h01; hit_all = 8'h01; perm_r = 8'h01; assoc = 8'h01;
        req_acc = 2'd0; fire();
        expect_rsp("R5 read granted", 1, 1, 4'h0, 0, 8'h00);
        req_acc = 2'd1; fire();
        expect_rsp("R5 write denied", 1, 0, 4'h2, 0, 8'h00);
        req_acc = 2'd2; cfg_chk_x = 1'b1; fire();
        expect_rsp("R5 R9 fetch denied by x", 1, 0, 4'h3, 0, 8'h00);
        req_acc = 2'd3; perm_r = 8'h00; fire();
        expect_rsp("R5 code 3 as read", 1, 0, 4'h1, 0, 8'h00);
    endtask

    task automatic t_nonprio();
        clear_entries();
        hit_any = 8'h60; hit_all = 8'h60; perm_r = 8'h40; assoc = 8'h60;
        req_acc = 2'd0; fire();
        expect_rsp("R6 one granting np entry", 1, 1, 4'h0, 6, 8'h60);
        req_acc = 2'd1; fire();
        expect_rsp("R7 np all deny write", 1, 0, 4'h2, 5, 8'h60);
        req_acc = 2'd2; cfg_chk_x = 1'b0; fire();
        expect_rsp("R9 fetch uses r when chk_x 0", 1, 1, 4'h0, 6, 8'h60);
        cfg_chk_x = 1'b1; fire();
        expect_rsp("R9 R7 fetch uses x when chk_x 1", 1, 0, 4'h3, 5, 8'h60);
    endtask

    task automatic t_nohit();
        clear_entries();
        perm_r = 8'hFF; assoc = 8'hFF; fire();
        expect_rsp("R8 nothing hits", 1, 0, 4'h5, 0, 8'h00);
        hit_any = 8'h40; fire();
        expect_rsp("R8 np partial does not qualify", 1, 0, 4'h5, 0, 8'h00);
        hit_any = 8'h80; hit_all = 8'h80; assoc = 8'h7F; fire();
        expect_rsp("R8 unassociated np full hit", 1, 0, 4'h5, 0, 8'h00);
    endtask

    task automatic t_boundary();
        clear_entries();
        cfg_prio_entry = 4'd0;
        hit_any = 8'h03; hit_all = 8'h02; perm_r = 8'h03; assoc = 8'h03; fire();
        expect_rsp("R3 R6 boundary zero all np", 1, 1, 4'h0, 1, 8'h02);
        cfg_prio_entry = 4'd8; hit_any = 8'h80; hit_all = 8'h80; perm_r = 8'h00; assoc = 8'h80; fire();
        expect_rsp("R5 boundary eight all priority", 1, 0, 4'h1, 7, 8'h00);
    endtask

    task automatic t_hold();
        clear_entries();
        hit_any = 8'h01; hit_all = 8'h01; perm_r = 8'h01; assoc = 8'h01; fire();
        expect_rsp("R10 setup", 1, 1, 4'h0, 0, 8'h00);
        req_rrid = 4'd15; hit_all = 8'h00;
        @(negedge clk); @(negedge clk);
        expect_rsp("R10 idle inputs ignored", 0, 1, 4'h0, 0, 8'h00);
    endtask

    initial begin
        clear_entries();
        #1;
        expect_rsp("R10 reset state", 0, 0, 4'h0, 0, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_rsp("R10 after reset release", 0, 0, 4'h0, 0, 8'h00);
        t_rrid();
        t_blocked();
        t_prio_order();
        t_partial();
        t_prio_perm();
        t_nonprio();
        t_nohit();
        t_boundary();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule